// File: doc/BRIEF.md
# Multichannel TDM Serial Framer

The framer moves fixed-width words between a time-division-multiplexed serial line and two parallel word streams. All logic runs on one system clock. `bit_tick` marks each serial bit period, and `fsync_in` marks a frame start on that tick. After the sync the framer waits a programmable gap of bit periods. It then shifts one word per channel slot, MSB first, on both the serial input and the serial output. Once the last slot of the frame is done it goes idle until the next sync.

Transmit words enter through a one-entry holding register and are fetched one slot ahead. A slot with no word sends zeros and raises an underflow pulse. Each received word leaves through a valid/ready output register together with its slot index. A self-test loopback mode feeds the transmit bit stream back into the receiver. In that mode the framer also produces its own frame syncs. The settings are captured from the configuration pins only while the framer is disabled.

Back-pressure rules: `tx_ready` is high only while the framer is enabled and its holding register is empty. A word is taken on a clock where `tx_valid` and `tx_ready` are both high. `rx_valid`, `rx_data` and `rx_slot` hold steady until `rx_ready` is seen high. A received word that completes while the output register is still occupied and not being accepted is dropped, and the older word stays. Disabling the framer empties both registers.

Top module: `tdm_framer`

## Requirements
- R1: While disabled (both mode enables low) or in reset: `rx_valid`, `tx_ready`, `tx_underflow` and `sdata_out` are all 0.
- R2: With a gap setting g, the first data bit of slot 0 is sampled on the g-th bit tick after the sync tick. When g = 0 it is sampled on the sync tick itself.
- R3: With `cfg_multi_en` = 1, a frame holds `cfg_last_slot`+1 slots, numbered 0 upward on `rx_slot`. After the last slot, further bit ticks without a sync produce no words.
- R4: Received bits are assembled MSB first: the first sampled bit of a slot becomes bit WORD_W-1 of `rx_data`.
- R5: `sdata_out` carries the current transmit word MSB first. During the cycle before each data tick it shows the bit for that tick.
- R6: A slot that starts with no transmit word loaded sends all zeros. `tx_underflow` is then high for exactly one clock.
- R7: A sync that arrives in the middle of a word abandons that word and restarts the gap count at slot 0. Its partial data produces no received word.
- R8: With `cfg_multi_en` = 0 and `cfg_single_en` = 1, every frame holds exactly one slot (slot 0), and `cfg_last_slot` has no effect. When `cfg_multi_en` = 1, the single-channel enable has no further effect.
- R9: With `cfg_loopback` = 1 and `cfg_multi_en` = 0, the receiver takes the transmit bit stream, and `sdata_in` and `fsync_in` are ignored. A new frame starts on every bit tick that finds the framer idle.
- R10: With `cfg_multi_en` = 1, `cfg_loopback` has no effect: data comes from `sdata_in` and frames from `fsync_in`.
- R11: Gap, slot count and loopback settings are captured only while the framer is disabled. Pin changes made while enabled are ignored.
- R12: A held `rx_valid` keeps `rx_data` and `rx_slot` stable until accepted. A word completing while the register is occupied and not accepted is dropped.
- R13: `tx_ready` is 1 when enabled with an empty holding register. After one word has been loaded into the shifter and a second one is buffered, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| fsync_in | input | 1 | Frame sync, sampled on bit ticks |
| sdata_in | input | 1 | Serial receive data, sampled on data ticks |
| sdata_out | output | 1 | Serial transmit data |
| cfg_multi_en | input | 1 | Multichannel mode enable |
| cfg_single_en | input | 1 | Single-slot mode enable |
| cfg_loopback | input | 1 | Self-test loopback (single-slot mode only) |
| cfg_gap | input | DLY_W | Bit ticks from sync to first data bit |
| cfg_last_slot | input | SLOT_W | Slot count minus one |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register can take a word |
| tx_data | input | WORD_W | Transmit word |
| tx_underflow | output | 1 | One-clock pulse: slot started with no word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer accepts the received word |
| rx_data | output | WORD_W | Received word |
| rx_slot | output | SLOT_W | Slot index of the received word |

## Verification
A gap or bit counter that is off by one misaligns every received word. The error reaches `rx_data` on the first completed slot, one gap plus WORD_W ticks after the sync, and the serial output drifts from the expected bit on the very next data tick. A wrong slot counter shows up at the end of the frame as a missing word, an extra word or a wrong `rx_slot`. A holding register that is mis-tracked shows up as a stray or missing `tx_underflow` pulse one clock after the next slot starts, or as a wrong `tx_ready` level before any tick arrives.

// File: rtl/tdm_framer_pkg.sv
package tdm_framer_pkg;

  localparam int DLY_W  = 4;
  localparam int SLOT_W = 7;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_GAP,
    PH_DATA
  } phase_e;

  typedef struct packed {
    logic              multi;
    logic              single;
    logic              loop;
    logic [DLY_W-1:0]  gap;
    logic [SLOT_W-1:0] last_slot;
  } cfg_t;

endpackage

// File: rtl/tdm_cfg_hold.sv
module tdm_cfg_hold
  import tdm_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg_in,
  output cfg_t              cfg_q,
  output logic              run,
  output logic              loop_act,
  output logic [SLOT_W-1:0] last_eff
);

  assign run      = cfg_q.multi | cfg_q.single;
  assign loop_act = cfg_q.loop & ~cfg_q.multi;
  assign last_eff = cfg_q.multi ? cfg_q.last_slot : '0;

  // Settings are captured while stopped; while running only a full disable is honoured.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (!run) begin
      cfg_q <= cfg_in;
    end else if (!(cfg_in.multi || cfg_in.single)) begin
      cfg_q.multi  <= 1'b0;
      cfg_q.single <= 1'b0;
    end
  end

endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_framer_pkg::*;
#(
  parameter int WORD_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              sync,
  input  logic [DLY_W-1:0]  gap,
  input  logic [SLOT_W-1:0] last_slot,
  output logic              proc,
  output logic              word_start,
  output logic              word_end,
  output logic              abort,
  output logic              bits_busy,
  output logic              idle,
  output logic [SLOT_W-1:0] slot_cur
);

  localparam int BIT_W = $clog2(WORD_W);

  phase_e            phase;
  logic [DLY_W-1:0]  gcnt;
  logic [BIT_W-1:0]  bcnt;
  logic [SLOT_W-1:0] scnt;
  logic [BIT_W-1:0]  bit_cur;
  logic              fresh;

  // A sync tick or the tick ending the gap starts at bit 0 of slot 0.
  assign fresh    = sync || (phase != PH_DATA);
  assign bit_cur  = fresh ? '0 : bcnt;
  assign slot_cur = fresh ? '0 : scnt;

  always_comb begin
    proc = 1'b0;
    if (run && tick) begin
      if (sync)                proc = (gap == '0);
      else if (phase == PH_GAP) proc = (gcnt == DLY_W'(1));
      else                     proc = (phase == PH_DATA);
    end
  end

  assign word_start = proc && (bit_cur == '0);
  assign word_end   = proc && (bit_cur == BIT_W'(WORD_W - 1));
  assign bits_busy  = (phase == PH_DATA) && (bcnt != '0);
  assign abort      = run && tick && sync && bits_busy;
  assign idle       = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= PH_IDLE;
      gcnt  <= '0;
      bcnt  <= '0;
      scnt  <= '0;
    end else if (tick) begin
      if (proc) begin
        if (word_end) begin
          bcnt <= '0;
          if (slot_cur == last_slot) begin
            phase <= PH_IDLE;
            scnt  <= '0;
          end else begin
            phase <= PH_DATA;
            scnt  <= slot_cur + 1'b1;
          end
        end else begin
          phase <= PH_DATA;
          bcnt  <= bit_cur + 1'b1;
          scnt  <= slot_cur;
        end
      end else if (sync) begin
        phase <= PH_GAP;
        gcnt  <= gap;
        bcnt  <= '0;
        scnt  <= '0;
      end else if (phase == PH_GAP) begin
        gcnt <= gcnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
  parameter int WORD_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              proc,
  input  logic              word_start,
  input  logic              word_end,
  input  logic              abort,
  input  logic              bits_busy,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              ser_bit,
  output logic              underflow
);

  logic [WORD_W-1:0] hold;
  logic [WORD_W-1:0] sh;
  logic              full;
  logic              loaded;

  assign in_ready = run && !full;
  assign ser_bit  = sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      hold      <= '0;
      sh        <= '0;
      full      <= 1'b0;
      loaded    <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= word_start && (!loaded || abort);
      if (in_valid && in_ready) begin
        hold <= in_data;
        full <= 1'b1;
      end
      if (word_end) begin
        // Hand the next slot its word at once so back-to-back ticks never starve it.
        if (full) begin
          sh     <= hold;
          loaded <= 1'b1;
          full   <= 1'b0;
        end else begin
          sh     <= '0;
          loaded <= 1'b0;
        end
      end else if (abort) begin
        sh     <= '0;
        loaded <= 1'b0;
      end else if (proc) begin
        sh <= sh << 1;
      end else if (!loaded && full && !bits_busy) begin
        sh     <= hold;
        loaded <= 1'b1;
        full   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_framer_pkg::*;
#(
  parameter int WORD_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              proc,
  input  logic              word_end,
  input  logic [SLOT_W-1:0] slot_cur,
  input  logic              ser_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [SLOT_W-1:0] out_slot
);

  logic [WORD_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      sh        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_slot  <= '0;
    end else begin
      if (proc) sh <= {sh[WORD_W-3:0], ser_bit};
      if (word_end && (!out_valid || out_ready)) begin
        out_data  <= {sh, ser_bit};
        out_slot  <= slot_cur;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_framer_pkg::*;
#(
  parameter int WORD_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              fsync_in,
  input  logic              sdata_in,
  output logic              sdata_out,
  input  logic              cfg_multi_en,
  input  logic              cfg_single_en,
  input  logic              cfg_loopback,
  input  logic [DLY_W-1:0]  cfg_gap,
  input  logic [SLOT_W-1:0] cfg_last_slot,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_underflow,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic [SLOT_W-1:0] rx_slot
);

  cfg_t              cfg_in;
  cfg_t              cfg_q;
  logic              run;
  logic              loop_act;
  logic [SLOT_W-1:0] last_eff;
  logic              proc, word_start, word_end, abort, bits_busy, idle;
  logic [SLOT_W-1:0] slot_cur;
  logic              tx_bit;
  logic              sync_eff;
  logic              rx_bit;

  assign cfg_in = {cfg_multi_en, cfg_single_en, cfg_loopback, cfg_gap, cfg_last_slot};

  // In loopback the transmit side is master: it frames itself and feeds the receiver.
  assign sync_eff  = loop_act ? idle : fsync_in;
  assign rx_bit    = loop_act ? tx_bit : sdata_in;
  assign sdata_out = tx_bit;

  tdm_cfg_hold u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_in   (cfg_in),
    .cfg_q    (cfg_q),
    .run      (run),
    .loop_act (loop_act),
    .last_eff (last_eff)
  );

  tdm_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (bit_tick),
    .sync       (sync_eff),
    .gap        (cfg_q.gap),
    .last_slot  (last_eff),
    .proc       (proc),
    .word_start (word_start),
    .word_end   (word_end),
    .abort      (abort),
    .bits_busy  (bits_busy),
    .idle       (idle),
    .slot_cur   (slot_cur)
  );

  tdm_tx_lane #(.WORD_W(WORD_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .proc       (proc),
    .word_start (word_start),
    .word_end   (word_end),
    .abort      (abort),
    .bits_busy  (bits_busy),
    .in_valid   (tx_valid),
    .in_ready   (tx_ready),
    .in_data    (tx_data),
    .ser_bit    (tx_bit),
    .underflow  (tx_underflow)
  );

  tdm_rx_lane #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .proc      (proc),
    .word_end  (word_end),
    .slot_cur  (slot_cur),
    .ser_bit   (rx_bit),
    .out_valid (rx_valid),
    .out_ready (rx_ready),
    .out_data  (rx_data),
    .out_slot  (rx_slot)
  );

endmodule

// File: rtl/tdm_framer_chk.sv
module tdm_framer_chk
  import tdm_framer_pkg::*;
#(
  parameter int WORD_W = 32
)(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              multi,
  input logic              loop_act,
  input logic [DLY_W-1:0]  gap_q,
  input logic [SLOT_W-1:0] last_eff,
  input logic              sdata_in,
  input logic              rx_bit,
  input logic              tx_ready,
  input logic              tx_underflow,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic [SLOT_W-1:0] rx_slot
);

  // R1: stopped framer offers no handshake and flushes its outputs
  a_r1_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tx_ready);
  a_r1_stopped_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !rx_valid && !tx_underflow);

  // R3: reported slot never exceeds the frame's last slot
  a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n || !run)
    rx_valid |-> rx_slot <= last_eff);

  // R6: underflow is a single-clock pulse
  a_r6_underflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |=> !tx_underflow);

  // R10: multichannel mode always listens to the external line
  a_r10_multi_uses_pin: assert property (@(posedge clk) disable iff (!rst_n)
    multi |-> rx_bit == sdata_in);

  // R11: captured settings stay put while running
  a_r11_settings_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> $stable(gap_q) && $stable(last_eff) && $stable(loop_act));

  // R12: an unaccepted word is held unchanged
  a_r12_rx_hold: assert property (@(posedge clk) disable iff (!rst_n || !run)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_slot));

endmodule

bind tdm_framer tdm_framer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .multi        (cfg_q.multi),
  .loop_act     (loop_act),
  .gap_q        (cfg_q.gap),
  .last_eff     (last_eff),
  .sdata_in     (sdata_in),
  .rx_bit       (rx_bit),
  .tx_ready     (tx_ready),
  .tx_underflow (tx_underflow),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_data      (rx_data),
  .rx_slot      (rx_slot)
);

// File: tb/tdm_framer_test.sv
module tdm_framer_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bit_tick = 1'b0, fsync_in = 1'b0, sdata_in = 1'b0;
  logic         sdata_out;
  logic         cfg_multi_en = 1'b0, cfg_single_en = 1'b0, cfg_loopback = 1'b0;
  logic [3:0]   cfg_gap = '0;
  logic [6:0]   cfg_last_slot = '0;
  logic         tx_valid = 1'b0;
  logic         tx_ready;
  logic [W-1:0] tx_data = '0;
  logic         tx_underflow;
  logic         rx_valid;
  logic         rx_ready = 1'b1;
  logic [W-1:0] rx_data;
  logic [6:0]   rx_slot;

  tdm_framer #(.WORD_W(W)) uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [W-1:0] txw [8];
  logic [W-1:0] rxw [8];
  int tx_n = 0, tx_i = 0, rx_got = 0, ufl_cnt = 0, slot_mod = 1;
  bit chk_rx = 1'b0;
  bit finished = 1'b0;

  typedef struct packed {
    logic       mc;
    logic       lp;
    logic [3:0] gap;
    logic [6:0] last;
    logic [3:0] nexp;
    logic [7:0] base;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b1, 1'b0, 4'd0,  7'd3, 4'd4, 8'hA5},
    '{1'b1, 1'b0, 4'd3,  7'd0, 4'd1, 8'h3C},
    '{1'b1, 1'b0, 4'd15, 7'd2, 4'd3, 8'h81},
    '{1'b1, 1'b1, 4'd1,  7'd1, 4'd2, 8'h5A},   // R10: loopback pin set in multichannel mode
    '{1'b0, 1'b0, 4'd2,  7'd5, 4'd1, 8'hC3}    // R8: single-slot mode ignores slot count
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic fs, input logic sd);
    bit acc;
    @(negedge clk);
    bit_tick = tk;
    fsync_in = fs;
    sdata_in = sd;
    if (tx_i < tx_n) begin
      tx_valid = 1'b1;
      tx_data  = txw[tx_i];
      acc      = tx_ready;
    end else begin
      tx_valid = 1'b0;
      acc      = 1'b0;
    end
    @(posedge clk);
    if (acc) tx_i++;
    #1;
    if (rx_valid && rx_ready) begin
      if (chk_rx) begin
        check(rx_data == rxw[rx_got % 8], "R4 received word", rx_data, rxw[rx_got % 8]);
        check(rx_slot == 7'(rx_got % slot_mod), "R3 slot index", rx_slot, rx_got % slot_mod);
      end
      rx_got++;
    end
    if (tx_underflow) ufl_cnt++;
  endtask

  task automatic apply_cfg(input logic mc, input logic sc, input logic lp,
                           input logic [3:0] g, input logic [6:0] last);
    cfg_multi_en = 1'b0; cfg_single_en = 1'b0;
    step(0, 0, 0); step(0, 0, 0);
    cfg_multi_en = mc; cfg_single_en = sc; cfg_loopback = lp;
    cfg_gap = g; cfg_last_slot = last;
    step(0, 0, 0); step(0, 0, 0);
  endtask

  // Drives one frame from an external sync; checks words, serial output and underflow.
  task automatic run_frame(input int gap, input int nexp, input logic [7:0] base,
                           input bit use_tx, input bit hold_rdy);
    int mism;
    int nbits;
    for (int s = 0; s < 8; s++) begin
      rxw[s] = base ^ W'(s * 29);
      txw[s] = ~rxw[s];
    end
    tx_n = use_tx ? nexp : 0;
    tx_i = 0; rx_got = 0; ufl_cnt = 0; mism = 0;
    slot_mod = nexp; chk_rx = !hold_rdy;
    rx_ready = !hold_rdy;
    for (int c = 0; c < 6; c++) step(0, 0, 0);
    nbits = gap + nexp * W;
    for (int k = 0; k < nbits; k++) begin
      logic bv, ov;
      bv = 1'b0; ov = 1'b0;
      if (k >= gap) begin
        bv = rxw[(k - gap) / W][W - 1 - ((k - gap) % W)];
        ov = use_tx ? txw[(k - gap) / W][W - 1 - ((k - gap) % W)] : 1'b0;
        if (sdata_out !== ov) mism++;
      end
      step(1, k == 0, bv);
      step(0, 0, 0);
    end
    for (int k = 0; k < 2 * W; k++) begin
      step(1, 0, 1);
      step(0, 0, 0);
    end
    if (!hold_rdy) check(rx_got == nexp, "R3 words per frame", rx_got, nexp);
    check(mism == 0, "R5 serial output bits", mism, 0);
    check(ufl_cnt == (use_tx ? 0 : nexp), "R6 underflow pulses", ufl_cnt, use_tx ? 0 : nexp);
    chk_rx = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(!rx_valid && !tx_ready && !tx_underflow && !sdata_out, "R1 reset outputs",
          {rx_valid, tx_ready, tx_underflow, sdata_out}, 0);
    step(0, 0, 0);
    rst_n = 1'b1;
    step(0, 0, 0);
    check(!tx_ready && !rx_valid, "R1 disabled idle", {tx_ready, rx_valid}, 0);

    // Vector table: R2 gaps 0/3/15, R3 slot counts, R4/R5 bit order, R8, R10
    for (int v = 0; v < 5; v++) begin
      apply_cfg(VEC[v].mc, 1'b1, VEC[v].lp, VEC[v].gap, VEC[v].last);
      run_frame(int'(VEC[v].gap), int'(VEC[v].nexp), VEC[v].base, 1'b1, 1'b0);
    end

    // R13: ready reflects the one-entry holding register
    apply_cfg(1'b1, 1'b0, 1'b0, 4'd0, 7'd1);
    check(tx_ready == 1'b1, "R13 ready when empty", tx_ready, 1);
    txw[0] = 8'h11; txw[1] = 8'h22; tx_n = 2; tx_i = 0;
    for (int c = 0; c < 6; c++) step(0, 0, 0);
    check(tx_i == 2 && tx_ready == 1'b0, "R13 ready low when full", {tx_i[3:0], tx_ready}, 5'h4);
    tx_n = 0;

    // R6 and R7: partial word then a restarting sync, no transmit data
    apply_cfg(1'b1, 1'b0, 1'b0, 4'd0, 7'd1);
    step(1, 1, 1); step(0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 1); step(0, 0, 0);
    end
    check(rx_valid == 1'b0, "R7 no word from partial frame", rx_valid, 0);
    run_frame(0, 2, 8'h6E, 1'b0, 1'b0);

    // R11: pin changes while enabled are ignored
    apply_cfg(1'b1, 1'b0, 1'b0, 4'd0, 7'd0);
    cfg_gap = 4'd5; cfg_last_slot = 7'd3;
    run_frame(0, 1, 8'h97, 1'b1, 1'b0);

    // R12: back-pressure holds the first word and drops the rest
    apply_cfg(1'b1, 1'b0, 1'b0, 4'd0, 7'd2);
    run_frame(0, 3, 8'h48, 1'b1, 1'b1);
    check(rx_valid == 1'b1, "R12 word held", rx_valid, 1);
    check(rx_data == rxw[0] && rx_slot == 7'd0, "R12 oldest word kept", {rx_slot, rx_data}, {7'd0, rxw[0]});
    rx_ready = 1'b1;
    step(0, 0, 0);
    step(0, 0, 0);
    check(rx_valid == 1'b0, "R12 later words dropped", rx_valid, 0);

    // R9: loopback frames itself and ignores the external pins
    apply_cfg(1'b0, 1'b1, 1'b1, 4'd2, 7'd0);
    txw[0] = 8'h3E; txw[1] = 8'hC1;
    rxw[0] = 8'h3E; rxw[1] = 8'hC1; rxw[2] = 8'h00;
    tx_n = 2; tx_i = 0; rx_got = 0; slot_mod = 1; chk_rx = 1'b1; rx_ready = 1'b1;
    for (int c = 0; c < 6; c++) step(0, 0, 0);
    for (int k = 0; k < 30; k++) begin
      step(1, (k % 4) == 1, 1);
      step(0, 0, 0);
    end
    chk_rx = 1'b0;
    check(rx_got == 3, "R9 loopback word count", rx_got, 3);

    // R1: disabling flushes the interface
    cfg_multi_en = 1'b0; cfg_single_en = 1'b0;
    step(0, 0, 0); step(0, 0, 0);
    check(!tx_ready && !rx_valid && !sdata_out, "R1 after disable",
          {tx_ready, rx_valid, sdata_out}, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule